// File: doc/BRIEF.md
# Toggle Coverage Vector Selector

This block sits beside a logic simulation and decides, at the end of every test vector, whether that vector should become a quiescent-current measurement point. For every monitored node it records whether the node has already been seen at logic 1 and at logic 0 in a previously accepted vector. A candidate vector is scored by the number of those flags it would set for the first time. The vector is kept only when that score is a large enough share of the flags that are still clear. The share is a programmable percentage.

A vector is never eligible while any node is unknown or while a driver conflict is flagged. The number of accepted vectors is capped. The usual flow is to run a pass at a strict percentage and then restart with a looser percentage. The restart keeps every flag and count from the earlier passes. The block reports acceptance, the running count of set flags and a done indication. All outputs are registered.

Top module: `toggle_vec_sel`

## Requirements
- R1: A reset (`rst`) or a synchronous clear (`clr`) empties every one-flag and zero-flag and sets `covered` and the accepted count to 0 with `accept` low. It loads the percentage from `pct_in` and the cap from `max_accept`. `done` then equals (`max_accept` == 0).
- R2: A strobed vector with any `node_unk` bit set, or with `contention` high, is rejected and changes no flag or count.
- R3: The new-coverage score of a vector is the number of nodes at 1 whose one-flag is clear, plus the number of nodes at 0 whose zero-flag is clear.
- R4: An eligible strobed vector is accepted when score > 0 and score×100 ≥ pct×uncovered, where uncovered = 2·N − `covered`. `accept` is high for exactly the one cycle after the strobe edge.
- R5: On acceptance, each node's flag for its current value is set and `covered` grows by the score. A rejected vector leaves all flags and `covered` unchanged.
- R6: Each acceptance adds one to the accepted count. Once that count reaches the loaded cap, `done` is high and later strobes are rejected.
- R7: When `covered` equals 2·N, `done` is high and later strobes are rejected.
- R8: `pct_in` and `max_accept` are ignored except during reset, clear or a `pass_restart` cycle. A restart loads both values but keeps all flags, `covered` and the accepted count.
- R9: With `vec_strobe` low, node inputs have no effect and `accept` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of flags and counts; reloads settings |
| pass_restart | input | 1 | Loads new percentage and cap, keeps coverage |
| pct_in | input | PCT_W | Acceptance percentage |
| max_accept | input | ACC_W | Cap on accepted vectors |
| vec_strobe | input | 1 | End-of-vector sample strobe |
| node_val | input | N | Node values at end of vector |
| node_unk | input | N | Per-node unknown flags |
| contention | input | 1 | Driver conflict present in this vector |
| accept | output | 1 | Vector accepted (one cycle after strobe) |
| covered | output | CNT_W | Number of set one/zero flags |
| done | output | 1 | Cap reached or full coverage |

## Verification
A flag set wrongly, or one that fails to set, has no immediate effect at the ports. It shows up on a later strobe, either as a wrong `covered` increment or as a flipped accept decision at the percentage boundary. The bench therefore replays the same node patterns and near-boundary scores after each acceptance. A wrong percentage or cap register shows up at the first strobe after a load. A broken eligibility gate shows up in the cycle after the bad vector, through `accept` and `covered`.

// File: rtl/tcvs_pkg.sv
package tcvs_pkg;
  localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/tcvs_popcount.sv
module tcvs_popcount #(
  parameter int W  = 32,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + OW'(bits[i]);
  end
endmodule

// File: rtl/tcvs_flag_bank.sv
module tcvs_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         wipe,
  input  logic         upd,
  input  logic [N-1:0] node_val,
  output logic [N-1:0] fresh_hi,
  output logic [N-1:0] fresh_lo
);
  for (genvar g = 0; g < N; g++) begin : g_node
    logic saw1_q, saw0_q;
    always_ff @(posedge clk) begin
      if (wipe) begin
        saw1_q <= 1'b0;
        saw0_q <= 1'b0;
      end else if (upd) begin
        saw1_q <= saw1_q | node_val[g];
        saw0_q <= saw0_q | ~node_val[g];
      end
    end
    assign fresh_hi[g] = node_val[g] & ~saw1_q;
    assign fresh_lo[g] = ~node_val[g] & ~saw0_q;
  end
endmodule

// File: rtl/tcvs_gate.sv
module tcvs_gate
  import tcvs_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int PCT_W = 7
) (
  input  logic [CNT_W-1:0] score,
  input  logic [CNT_W-1:0] uncov,
  input  logic [PCT_W-1:0] pct,
  output logic             pass
);
  localparam int MW = CNT_W + PCT_W + 1;
  logic [MW-1:0] lhs, rhs;
  always_comb begin
    lhs  = MW'(score) * MW'(PCT_SCALE);
    rhs  = MW'(pct) * MW'(uncov);
    pass = (score != '0) && (lhs >= rhs);
  end
endmodule

// File: rtl/toggle_vec_sel.sv
module toggle_vec_sel #(
  parameter int N     = 16,
  parameter int ACC_W = 8,
  parameter int PCT_W = 7,
  parameter int CNT_W = $clog2(2 * N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pass_restart,
  input  logic [PCT_W-1:0] pct_in,
  input  logic [ACC_W-1:0] max_accept,
  input  logic             vec_strobe,
  input  logic [N-1:0]     node_val,
  input  logic [N-1:0]     node_unk,
  input  logic             contention,
  output logic             accept,
  output logic [CNT_W-1:0] covered,
  output logic             done
);
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(2 * N);

  logic [N-1:0]     fresh_hi, fresh_lo;
  logic [CNT_W-1:0] score, uncov, cov_n;
  logic [ACC_W-1:0] acc_q, acc_n, max_q, max_n;
  logic [PCT_W-1:0] pct_q;
  logic             eligible, pass, take, wipe;

  assign wipe     = rst | clr;
  assign uncov    = TOTAL - covered;
  assign eligible = vec_strobe & ~contention & ~(|node_unk) & ~done;
  assign take     = eligible & pass;

  tcvs_flag_bank #(.N(N)) u_flags (
    .clk(clk), .wipe(wipe), .upd(take), .node_val(node_val),
    .fresh_hi(fresh_hi), .fresh_lo(fresh_lo)
  );

  tcvs_popcount #(.W(2 * N), .OW(CNT_W)) u_pop (
    .bits({fresh_hi, fresh_lo}), .count(score)
  );

  tcvs_gate #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_gate (
    .score(score), .uncov(uncov), .pct(pct_q), .pass(pass)
  );

  always_comb begin
    cov_n = take ? covered + score : covered;
    acc_n = take ? acc_q + ACC_W'(1) : acc_q;
    max_n = pass_restart ? max_accept : max_q;
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      covered <= '0;
      acc_q   <= '0;
      accept  <= 1'b0;
      pct_q   <= pct_in;
      max_q   <= max_accept;
      done    <= (max_accept == '0);
    end else begin
      accept  <= take;
      covered <= cov_n;
      acc_q   <= acc_n;
      max_q   <= max_n;
      if (pass_restart) pct_q <= pct_in;
      done    <= (cov_n == TOTAL) || (acc_n >= max_n);
    end
  end
endmodule

// File: rtl/toggle_vec_sel_chk.sv
module toggle_vec_sel_chk #(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(2 * N + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             vec_strobe,
  input logic [N-1:0]     node_unk,
  input logic             contention,
  input logic             accept,
  input logic [CNT_W-1:0] covered,
  input logic             done
);
  a_r2_ineligible: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && (contention || (node_unk != '0))) |=> !accept);
  a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !vec_strobe |=> !accept);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (accept || covered == $past(covered)));
  a_r5_grow: assert property (@(posedge clk) disable iff (rst)
    accept |-> covered > $past(covered));
  a_r6_done_blocks: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> !accept);
  a_r7_bound: assert property (@(posedge clk) disable iff (rst)
    covered <= CNT_W'(2 * N));
endmodule

bind toggle_vec_sel toggle_vec_sel_chk #(.N(N), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/toggle_vec_sel_test.sv
module toggle_vec_sel_test;
  localparam int N = 16, ACC_W = 8, PCT_W = 7, CNT_W = $clog2(2 * N + 1);

  logic clk = 0, rst = 1, clr = 0, pass_restart = 0, vec_strobe = 0, contention = 0;
  logic [PCT_W-1:0] pct_in = 10;
  logic [ACC_W-1:0] max_accept = 6;
  logic [N-1:0] node_val = '0, node_unk = '0;
  logic accept, done;
  logic [CNT_W-1:0] covered;

  int checks = 0, fails = 0;
  logic [N-1:0] m1, m0;
  int m_cov, m_acc, m_pct, m_max;
  logic m_done;

  toggle_vec_sel #(.N(N), .ACC_W(ACC_W), .PCT_W(PCT_W)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pop(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += v[i];
    return c;
  endfunction

  task automatic model_wipe();
    m1 = '0; m0 = '0; m_cov = 0; m_acc = 0;
    m_pct = pct_in; m_max = max_accept; m_done = (max_accept == 0);
  endtask

  task automatic do_clear(int pct, int mx);
    @(negedge clk);
    pct_in = PCT_W'(pct); max_accept = ACC_W'(mx); clr = 1;
    @(negedge clk);
    clr = 0; model_wipe();
    chk("R1 covered", covered, 0);
    chk("R1 done", done, m_done);
  endtask

  task automatic do_restart(int pct, int mx);
    @(negedge clk);
    pct_in = PCT_W'(pct); max_accept = ACC_W'(mx); pass_restart = 1;
    @(negedge clk);
    pass_restart = 0; m_pct = pct; m_max = mx;
    m_done = (m_cov == 2 * N) || (m_acc >= m_max);
    chk("R8 covered kept", covered, m_cov);
    chk("R8 done", done, m_done);
  endtask

  task automatic vec(logic [N-1:0] v, logic [N-1:0] u, logic c, string tag);
    int sc, unc;
    logic ok;
    @(negedge clk);
    node_val = v; node_unk = u; contention = c; vec_strobe = 1;
    sc  = pop(v & ~m1) + pop(~v & ~m0);
    unc = 2 * N - m_cov;
    ok  = !m_done && !c && (u == '0) && sc > 0 && sc * 100 >= m_pct * unc;
    @(negedge clk);
    vec_strobe = 0; node_unk = '0; contention = 0;
    if (ok) begin
      m1 |= v; m0 |= ~v; m_cov += sc; m_acc++;
    end
    m_done = (m_cov == 2 * N) || (m_acc >= m_max);
    chk({tag, " accept"}, accept, ok);
    chk({tag, " covered"}, covered, m_cov);
    chk({tag, " done"}, done, m_done);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0; model_wipe();
    chk("R1 reset accept", accept, 0);
    chk("R1 reset covered", covered, 0);
    chk("R1 reset done", done, 0);

    vec(16'hA5A5, 16'h0100, 0, "R2 unknown");
    vec(16'hA5A5, 16'h0000, 1, "R2 contention");
    vec(16'hA5A5, '0, 0, "R3 R4 first");
    vec(16'hA5A5, '0, 0, "R4 zero score");
    vec(16'hA5A4, '0, 0, "R4 below pct");
    pct_in = 5;
    vec(16'hA5A4, '0, 0, "R8 pct ignored");
    do_restart(5, 6);
    vec(16'hA5A4, '0, 0, "R8 lower pct");
    do_restart(20, 6);
    vec(16'hA5AA, '0, 0, "R4 exact boundary");

    // R9: node inputs without strobe
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      node_val = N'($urandom);
      @(negedge clk);
      chk("R9 accept", accept, 0);
      chk("R9 covered", covered, m_cov);
    end

    // R6: accepted-count cap
    do_clear(0, 3);
    for (int k = 0; k < 5; k++) vec(16'h0001 << k, '0, 0, "R6 cap");

    // R7: full coverage
    do_clear(0, 200);
    vec(16'h0000, '0, 0, "R7 zeros");
    vec(16'hFFFF, '0, 0, "R7 ones");
    vec(16'h1234, '0, 0, "R7 after full");

    // R1: cap of zero
    do_clear(10, 0);
    vec(16'h00FF, '0, 0, "R1 zero cap");

    // random passes, lowering the percentage
    for (int p = 0; p < 3; p++) begin
      if (p == 0) do_clear(60, 40);
      else do_restart(60 / (2 * p + 1), 40);
      for (int k = 0; k < 120; k++) begin
        logic [N-1:0] v, u;
        logic c;
        v = N'($urandom) & N'($urandom);
        if ($urandom_range(1) == 1) v = ~v;
        u = ($urandom_range(7) == 0) ? N'(1 << $urandom_range(N - 1)) : '0;
        c = ($urandom_range(7) == 0);
        vec(v, u, c, "R2 R4 R5 random");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule